// File: doc/BRIEF.md
# Filtered CAN Receive Queue

This block sits behind a CAN receive engine that has already decoded each frame into an identifier, an extended-format flag, a length code and eight data bytes. Each incoming frame is compared against a table of sixteen acceptance filter elements. If any enabled element matches, the frame is placed in a six-entry queue together with the index of the element that accepted it. If no element matches, the frame is discarded.

The lower ten filter elements each have a private mask. The upper six all share one common mask. Software reads the queue through a show-ahead port: the oldest frame is always visible on the read outputs, and a one-cycle pop request removes it. An interrupt line stays high while the queue holds anything. A sticky overflow flag records lost frames, and a sticky warning flag records that the queue filled to its warning level. Both flags are cleared by write-one-to-clear strobes.

Filter and mask tables are written through a simple write port while the block is disabled. While the block is enabled, writes to the tables are ignored and received frames are filtered.

Top module: `canrxf_top`

## Requirements
- R1: The queue stores up to 6 accepted frames without any pop, and its occupancy never exceeds 6.
- R2: A frame accepted while the queue already holds 6 entries (counted at the start of that cycle) is not stored, and it sets the sticky `ovfFlag` on the next cycle.
- R3: `irq` is high exactly while at least one frame is waiting. The head frame and its filter index appear on the `rd*` outputs one cycle after it is stored into an empty queue.
- R4: A `popReq` pulse removes exactly one frame and advances the head in arrival order. `irq` stays high if frames remain. A pop on an empty queue is ignored.
- R5: A mask bit of 1 requires the frame identifier bit to equal the filter identifier bit, and a mask bit of 0 ignores that bit. The frame `ide` must equal the filter's `ide`, and the element must be enabled. Standard identifiers occupy bits 10:0 of the 29-bit identifier, with the upper bits zero.
- R6: Elements 0 to 9 use individual masks, which are written with `cfgSel`=1 and `cfgIdx` 0 to 9. Elements 10 to 15 all use one shared mask, which is written with `cfgSel`=1 and any `cfgIdx` from 10 to 15.
- R7: When several elements match, the lowest-numbered element accepts the frame, and its index is stored with the frame and output on `rdHit`.
- R8: `warnFlag` is set when a store brings the occupancy to 5. `flagClr` bit 0 clears `ovfFlag` and bit 1 clears `warnFlag`. A set in the same cycle as a clear takes precedence.
- R9: A store and a pop in the same cycle are both performed, and the occupancy is unchanged.
- R10: Table writes (`cfgWe` with `cfgSel`=0 writing identifier, `ide` and enable for element `cfgIdx`) take effect only while `enable` is 0. Frames are filtered only while `enable` is 1, and are ignored otherwise.
- R11: After reset the queue is empty, `irq`, `ovfFlag` and `warnFlag` are 0, every element is disabled, and every mask is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | 1: filter frames; 0: allow table writes |
| cfgWe | input | 1 | Table write strobe |
| cfgSel | input | 1 | 0: filter element, 1: mask |
| cfgIdx | input | 4 | Element or mask index |
| cfgId | input | 29 | Identifier or mask value |
| cfgIde | input | 1 | Element extended-format flag |
| cfgEn | input | 1 | Element enable |
| frmValid | input | 1 | Decoded frame present this cycle |
| frmId | input | 29 | Frame identifier |
| frmIde | input | 1 | Frame extended-format flag |
| frmDlc | input | 4 | Frame length code |
| frmData | input | 64 | Frame data bytes |
| popReq | input | 1 | Remove head frame |
| flagClr | input | 2 | Write-one-to-clear: bit 0 overflow, bit 1 warning |
| rdId | output | 29 | Head identifier |
| rdIde | output | 1 | Head extended-format flag |
| rdDlc | output | 4 | Head length code |
| rdData | output | 64 | Head data bytes |
| rdHit | output | 4 | Index of the element that accepted the head frame |
| irq | output | 1 | Queue not empty |
| ovfFlag | output | 1 | Sticky frame-lost flag |
| warnFlag | output | 1 | Sticky warning-level flag |

## Verification
The assertions check the occupancy relations on every cycle:
- the occupancy bound;
- a drop when the queue is full, with the overflow flag set;
- the occupancy being held on a simultaneous store and pop;
- an ignored pop on an empty queue;
- `irq` staying high after a pop that leaves entries;
- the warning flag rising only at the warning level;
- the overflow clear.

Only the bench's scenarios show the following:
- the match semantics of individual versus shared masks;
- the `ide` separation;
- lowest-index priority;
- the stored hit index;
- ignored table writes while enabled;
- the arrival order of the frames read back.

// File: rtl/canrxf_pkg.sv
package canrxf_pkg;
  localparam int ID_W   = 29;
  localparam int DLC_W  = 4;
  localparam int DATA_W = 64;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              ide;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } canFrame_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic cfgWr;
  } fifoCtl_t;
endpackage

// File: rtl/canrxf_data.sv
module canrxf_data
  import canrxf_pkg::*;
#(
  parameter int NUM_FILT = 16,
  parameter int NUM_IND  = 10,
  parameter int DEPTH    = 6,
  parameter int HIT_W    = $clog2(NUM_FILT),
  parameter int PTR_W    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoCtl_t         ctl,
  input  logic             cfgSel,
  input  logic [HIT_W-1:0] cfgIdx,
  input  logic [ID_W-1:0]  cfgId,
  input  logic             cfgIde,
  input  logic             cfgEn,
  input  canFrame_t        frm,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  output logic             hitAny,
  output canFrame_t        headFrame,
  output logic [HIT_W-1:0] headHit
);
  logic [ID_W-1:0] fltId     [NUM_FILT];
  logic            fltIde    [NUM_FILT];
  logic            fltEn     [NUM_FILT];
  logic [ID_W-1:0] indMask   [NUM_IND];
  logic [ID_W-1:0] sharedMask;
  logic [ID_W-1:0] effMask   [NUM_FILT];
  logic [NUM_FILT-1:0] hitVec;
  logic [HIT_W-1:0]    hitIdx;

  canFrame_t        memF [DEPTH];
  logic [HIT_W-1:0] memH [DEPTH];

  // table writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_FILT; i++) begin
        fltId[i]  <= '0;
        fltIde[i] <= 1'b0;
        fltEn[i]  <= 1'b0;
      end
      for (int i = 0; i < NUM_IND; i++) indMask[i] <= '1;
      sharedMask <= '1;
    end else if (ctl.cfgWr && (int'(cfgIdx) < NUM_FILT)) begin
      if (!cfgSel) begin
        fltId[cfgIdx]  <= cfgId;
        fltIde[cfgIdx] <= cfgIde;
        fltEn[cfgIdx]  <= cfgEn;
      end else if (int'(cfgIdx) < NUM_IND) begin
        indMask[cfgIdx] <= cfgId;
      end else begin
        sharedMask <= cfgId;
      end
    end
  end

  // per-element compare; the mask source is picked by position
  for (genvar g = 0; g < NUM_FILT; g++) begin : g_filt
    if (g < NUM_IND) begin : g_ind
      assign effMask[g] = indMask[g];
    end else begin : g_shr
      assign effMask[g] = sharedMask;
    end
    assign hitVec[g] = fltEn[g] && (fltIde[g] == frm.ide) &&
                       (((frm.id ^ fltId[g]) & effMask[g]) == '0);
  end

  // lowest index wins
  always_comb begin
    hitIdx = '0;
    for (int i = NUM_FILT - 1; i >= 0; i--) begin
      if (hitVec[i]) hitIdx = HIT_W'(i);
    end
  end
  assign hitAny = |hitVec;

  always_ff @(posedge clk) begin
    if (ctl.push) begin
      memF[wrPtr] <= frm;
      memH[wrPtr] <= hitIdx;
    end
  end

  assign headFrame = memF[rdPtr];
  assign headHit   = memH[rdPtr];
endmodule

// File: rtl/canrxf_ctrl.sv
module canrxf_ctrl
  import canrxf_pkg::*;
#(
  parameter int DEPTH    = 6,
  parameter int WARN_LVL = 5,
  parameter int PTR_W    = $clog2(DEPTH),
  parameter int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cfgWe,
  input  logic             frmValid,
  input  logic             hitAny,
  input  logic             popReq,
  input  logic [1:0]       flagClr,
  output fifoCtl_t         ctl,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [CNT_W-1:0] count,
  output logic             irq,
  output logic             ovfFlag,
  output logic             warnFlag
);
  logic full, empty, accept, drop;
  logic [CNT_W-1:0] cntNext;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign accept = enable && frmValid && hitAny;
  assign drop   = accept && full;

  assign ctl.cfgWr = cfgWe && !enable;
  assign ctl.push  = accept && !full;
  assign ctl.pop   = popReq && !empty;

  always_comb begin
    cntNext = count;
    if (ctl.push && !ctl.pop)      cntNext = count + 1'b1;
    else if (ctl.pop && !ctl.push) cntNext = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
      ovfFlag  <= 1'b0;
      warnFlag <= 1'b0;
    end else begin
      count <= cntNext;
      if (ctl.push) wrPtr <= stepPtr(wrPtr);
      if (ctl.pop)  rdPtr <= stepPtr(rdPtr);
      ovfFlag  <= drop || (ovfFlag && !flagClr[0]);
      warnFlag <= (ctl.push && cntNext == CNT_W'(WARN_LVL)) ||
                  (warnFlag && !flagClr[1]);
    end
  end

  assign irq = !empty;
endmodule

// File: rtl/canrxf_top.sv
module canrxf_top
  import canrxf_pkg::*;
#(
  parameter int NUM_FILT = 16,
  parameter int NUM_IND  = 10,
  parameter int DEPTH    = 6,
  parameter int WARN_LVL = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        cfgWe,
  input  logic        cfgSel,
  input  logic [3:0]  cfgIdx,
  input  logic [28:0] cfgId,
  input  logic        cfgIde,
  input  logic        cfgEn,
  input  logic        frmValid,
  input  logic [28:0] frmId,
  input  logic        frmIde,
  input  logic [3:0]  frmDlc,
  input  logic [63:0] frmData,
  input  logic        popReq,
  input  logic [1:0]  flagClr,
  output logic [28:0] rdId,
  output logic        rdIde,
  output logic [3:0]  rdDlc,
  output logic [63:0] rdData,
  output logic [3:0]  rdHit,
  output logic        irq,
  output logic        ovfFlag,
  output logic        warnFlag
);
  localparam int HIT_W = $clog2(NUM_FILT);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  fifoCtl_t         ctl;
  canFrame_t        inFrame, headFrame;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] fifoCount;
  logic             hitAny;

  assign inFrame = '{id: frmId, ide: frmIde, dlc: frmDlc, data: frmData};

  canrxf_ctrl #(.DEPTH(DEPTH), .WARN_LVL(WARN_LVL), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWe(cfgWe), .frmValid(frmValid),
    .hitAny(hitAny), .popReq(popReq), .flagClr(flagClr), .ctl(ctl),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .count(fifoCount), .irq(irq),
    .ovfFlag(ovfFlag), .warnFlag(warnFlag)
  );

  canrxf_data #(.NUM_FILT(NUM_FILT), .NUM_IND(NUM_IND), .DEPTH(DEPTH),
                .HIT_W(HIT_W), .PTR_W(PTR_W)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgSel(cfgSel), .cfgIdx(cfgIdx),
    .cfgId(cfgId), .cfgIde(cfgIde), .cfgEn(cfgEn), .frm(inFrame),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .hitAny(hitAny),
    .headFrame(headFrame), .headHit(rdHit)
  );

  assign rdId   = headFrame.id;
  assign rdIde  = headFrame.ide;
  assign rdDlc  = headFrame.dlc;
  assign rdData = headFrame.data;
endmodule

// File: rtl/canrxf_chk.sv
module canrxf_chk #(
  parameter int DEPTH    = 6,
  parameter int WARN_LVL = 5,
  parameter int CNT_W    = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             frmValid,
  input logic             hitAny,
  input logic             popReq,
  input logic [1:0]       flagClr,
  input logic [CNT_W-1:0] count,
  input logic             irq,
  input logic             ovfFlag,
  input logic             warnFlag
);
  logic tryStore;
  assign tryStore = enable && frmValid && hitAny;

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R2
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    tryStore && count == CNT_W'(DEPTH) |=> ovfFlag);

  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    tryStore && !popReq && count == CNT_W'(DEPTH) |=> count == CNT_W'(DEPTH));

  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    popReq && count > CNT_W'(1) |=> irq);

  // R4
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    popReq && count == '0 && !(enable && frmValid) |=> !irq && count == '0);

  // R9
  push_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    tryStore && popReq && count != '0 && count != CNT_W'(DEPTH) |=> count == $past(count));

  // R8
  warn_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(warnFlag) |-> count == CNT_W'(WARN_LVL));

  // R8
  ovf_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagClr[0] && !(tryStore && count == CNT_W'(DEPTH)) |=> !ovfFlag);
endmodule

bind canrxf_top canrxf_chk #(.DEPTH(DEPTH), .WARN_LVL(WARN_LVL), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .frmValid(frmValid), .hitAny(hitAny),
  .popReq(popReq), .flagClr(flagClr), .count(fifoCount), .irq(irq),
  .ovfFlag(ovfFlag), .warnFlag(warnFlag)
);

// File: tb/canrxf_top_bench.sv
module canrxf_top_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, enable = 1'b0;
  logic cfgWe = 1'b0, cfgSel = 1'b0, cfgIde = 1'b0, cfgEn = 1'b0;
  logic [3:0] cfgIdx = '0;
  logic [28:0] cfgId = '0;
  logic frmValid = 1'b0, frmIde = 1'b0, popReq = 1'b0;
  logic [28:0] frmId = '0;
  logic [3:0] frmDlc = '0;
  logic [63:0] frmData = '0;
  logic [1:0] flagClr = '0;
  logic [28:0] rdId;
  logic rdIde, irq, ovfFlag, warnFlag;
  logic [3:0] rdDlc, rdHit;
  logic [63:0] rdData;

  canrxf_top u_canrxf_top (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [28:0] id; logic ide; logic [3:0] dlc; logic [63:0] data; int hit;
  } expItem_t;

  expItem_t sb[$];
  int total = 0, bad = 0;
  bit finished = 0;

  // bench copy of the tables, kept from the requirements
  logic [28:0] mId [16];
  logic        mIde[16], mEn[16];
  logic [28:0] mMask[10];
  logic [28:0] mShared;
  logic expOvf = 0, expWarn = 0;

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int modelHit(input logic [28:0] id, input logic ide);
    for (int i = 0; i < 16; i++) begin
      logic [28:0] m;
      m = (i < 10) ? mMask[i] : mShared;
      if (mEn[i] && mIde[i] == ide && ((id ^ mId[i]) & m) == '0) return i;
    end
    return -1;
  endfunction

  task automatic cfgWrite(input logic sel, input int idx, input logic [28:0] v,
                          input logic ide, input logic en);
    cfgWe = 1; cfgSel = sel; cfgIdx = 4'(idx); cfgId = v; cfgIde = ide; cfgEn = en;
    if (!enable) begin
      if (!sel) begin mId[idx] = v; mIde[idx] = ide; mEn[idx] = en; end
      else if (idx < 10) mMask[idx] = v;
      else mShared = v;
    end
    @(posedge clk); @(negedge clk);
    cfgWe = 0;
  endtask

  // driver: sends one frame, optionally popping in the same cycle
  task automatic sendFrame(input logic [28:0] id, input logic ide, input logic [3:0] dlc,
                           input logic doPop, input string tag);
    int hit, sz;
    expItem_t e;
    hit = enable ? modelHit(id, ide) : -1;
    sz = sb.size();
    frmValid = 1; frmId = id; frmIde = ide; frmDlc = dlc;
    frmData = {id[15:0], ~id[15:0], id[15:0] ^ 16'h5A5A, 12'h0, dlc};
    popReq = doPop;
    @(posedge clk);
    if (doPop && sz > 0) void'(sb.pop_front());
    if (hit >= 0 && sz < 6) begin
      e.id = id; e.ide = ide; e.dlc = dlc; e.data = frmData; e.hit = hit;
      sb.push_back(e);
      if (sb.size() == 5) expWarn = 1;
    end
    if (hit >= 0 && sz == 6) expOvf = 1;
    @(negedge clk);
    frmValid = 0; popReq = 0;
    check(64'(irq), 64'(sb.size() != 0), {tag, " irq"});
    check(64'(ovfFlag), 64'(expOvf), {tag, " ovf"});
    check(64'(warnFlag), 64'(expWarn), {tag, " warn"});
  endtask

  // monitor: compares the head with the scoreboard and pops it
  task automatic popCheck(input string tag);
    if (sb.size() == 0) begin
      check(64'(irq), 64'd0, {tag, " empty irq"});
    end else begin
      check(64'(irq), 64'd1, {tag, " irq"});
      check(64'(rdId), 64'(sb[0].id), {tag, " id"});
      check(64'(rdIde), 64'(sb[0].ide), {tag, " ide"});
      check(64'(rdDlc), 64'(sb[0].dlc), {tag, " dlc"});
      check(rdData, sb[0].data, {tag, " data"});
      check(64'(rdHit), 64'(sb[0].hit), {tag, " hit"});
    end
    popReq = 1;
    @(posedge clk);
    if (sb.size() != 0) void'(sb.pop_front());
    @(negedge clk);
    popReq = 0;
    check(64'(irq), 64'(sb.size() != 0), {tag, " irq after pop"});
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mId[i] = '0; mIde[i] = 0; mEn[i] = 0; end
    for (int i = 0; i < 10; i++) mMask[i] = '1;
    mShared = '1;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    check(64'(irq), 0, "R11 irq");
    check(64'(ovfFlag), 0, "R11 ovf");
    check(64'(warnFlag), 0, "R11 warn");
    enable = 1;
    sendFrame(29'h000, 0, 4'd1, 0, "R11 filters disabled");
    enable = 0;
    @(negedge clk);

    cfgWrite(0, 0, 29'h123, 0, 1);
    cfgWrite(0, 1, 29'h120, 0, 1);
    cfgWrite(1, 1, 29'h7F0, 0, 0);
    cfgWrite(0, 9, 29'h400, 0, 1);
    cfgWrite(1, 9, 29'h700, 0, 0);
    cfgWrite(0, 11, 29'h0AA, 0, 1);
    cfgWrite(0, 12, 29'h1ABCDE00, 1, 1);
    cfgWrite(1, 13, 29'h1FFFFF00, 0, 0); // R6 shared mask via index 13
    enable = 1;
    @(negedge clk);
    cfgWrite(0, 5, 29'h300, 0, 1);      // R10 ignored while enabled

    sendFrame(29'h123, 0, 4'd8, 0, "R7 overlap lowest");
    check(64'(rdHit), 0, "R3 R7 head hit");
    check(64'(rdId), 64'h123, "R3 head id");
    sendFrame(29'h12A, 0, 4'd2, 0, "R5 masked bits");
    sendFrame(29'h123, 1, 4'd3, 0, "R5 ide mismatch");
    sendFrame(29'h1ABCDE55, 1, 4'd4, 0, "R6 shared ext");
    sendFrame(29'h300, 0, 4'd5, 0, "R10 write while enabled");
    sendFrame(29'h0FF, 0, 4'd6, 0, "R6 shared std");
    sendFrame(29'h45A, 0, 4'd7, 0, "R8 reach warn");
    sendFrame(29'h123, 0, 4'd8, 0, "R1 sixth");
    sendFrame(29'h12B, 0, 4'd1, 0, "R2 drop");
    flagClr = 2'b11;
    @(posedge clk); @(negedge clk);
    flagClr = 2'b00;
    expOvf = 0; expWarn = 0;
    check(64'(ovfFlag), 0, "R8 ovf cleared");
    check(64'(warnFlag), 0, "R8 warn cleared");
    for (int i = 0; i < 6; i++) popCheck("R4 drain");
    popCheck("R4 empty pop");
    check(64'(ovfFlag), 0, "R4 ovf after empty pop");

    sendFrame(29'h123, 0, 4'd2, 0, "R9 fill a");
    sendFrame(29'h0FF, 0, 4'd3, 0, "R9 fill b");
    sendFrame(29'h45A, 0, 4'd4, 1, "R9 push pop");
    popCheck("R9 read 1");
    popCheck("R9 read 2");
    popCheck("R9 empty");

    enable = 0;
    sendFrame(29'h123, 0, 4'd1, 0, "R10 disabled frame");
    cfgWrite(0, 5, 29'h300, 0, 1);
    enable = 1;
    sendFrame(29'h300, 0, 4'd5, 0, "R10 write while disabled");
    popCheck("R10 read");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule